// File: doc/BRIEF.md
# Disk Controller Command Phase Sequencer

This block runs one command transaction on the host side of a byte-wide disk controller. The controller presents a status byte and a data port and takes writes to select, control and data registers. The sequencer selects the controller, sets the transfer mode, waits for the controller to take the select, and then moves through the controller's phases. At each step, two status bits tell it what the controller wants next. It sends command bytes and moves data bytes one at a time in programmed-I/O mode. In DMA mode it hands the data phase to an external DMA channel and waits for the controller interrupt.

The transaction ends with a completion byte. The sequencer then waits for the controller to release select. If the completion byte flags an error, the sequencer runs a second transaction on its own: a PIO sense command to the unit named in that byte. The sense reply bytes are marked on the input byte stream. Every wait is guarded by a cycle count that the caller loads. The result is reported as success, timeout or controller error. Interrupt acknowledge and detection of stray interrupts are handled here as well.

Top module: `disk_phase_seq`

## Requirements
- R1: On `start` while idle, the first bus write is a zero to the select register (address 0). The second is the mode value to the control register (address 1): 0x03 for DMA, 0x00 for PIO.
- R2: After the mode write, the sequencer waits for select status (bit 3). If that bit has not been seen after `tmo_limit` waiting cycles, the transaction ends with result 1 (timeout).
- R3: The phase is decoded from status bit 2 (command) and bit 1 (input). Command-only sends the next byte of `cmd_bytes`, byte 0 (bits 7:0) first, to the data register (address 2). Zero is sent once all bytes are used.
- R4: A PIO data-out phase (both bits clear) writes `src_data` and pulses `src_take` when `src_en` is set. Otherwise it writes 0x00.
- R5: A PIO data-in phase (input only) always reads the data port. The byte is delivered on `in_we` only when `dst_en` is set.
- R6: In DMA mode a data phase raises `dma_en` with no data-port access, until the acknowledged interrupt arrives.
- R7: Both bits set is the status phase. The completion byte is read and shown on `csb`, then the sequencer waits for select to clear. A clean byte (bit 1 clear) ends the transaction with `done` and result 0.
- R8: If completion byte bit 1 is set, a PIO sense command is issued: byte 0 = 0x03, byte 1 = completion bits 7:5 placed in bits 7:5, the rest 0. Its reply bytes appear on `in_we` with `in_sense` high, and the final result is 2.
- R9: The timeout count restarts at every wait. A wait for ready (status bit 0) that exceeds `tmo_limit` cycles ends the transaction with result 1.
- R10: `irq` with interrupt status (bit 4) set writes 0x00 to the control register in that cycle. A sequencer access wanted in the same cycle is held and performed one cycle later.
- R11: `irq` with bit 4 clear sets `irq_unexp`. It stays set until the next accepted `start`.
- R12: After reset the block is idle with no bus strobes. A `start` during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transaction (idle only) |
| dma_mode | input | 1 | 1 = DMA data phases, 0 = PIO |
| cmd_bytes | input | 48 | Command block, byte 0 in bits 7:0 |
| src_en | input | 1 | Data-out source present |
| src_data | input | 8 | Next data-out byte |
| dst_en | input | 1 | Data-in destination present |
| tmo_limit | input | 16 | Waiting cycles allowed per wait |
| ctl_status | input | 5 | Controller status: int, select, command, input, ready |
| rd_data | input | 8 | Data port read value |
| irq | input | 1 | Controller interrupt |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 2 | 0 select, 1 control, 2 data |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | Data port read strobe |
| src_take | output | 1 | Source byte consumed |
| in_we | output | 1 | Input byte valid |
| in_sense | output | 1 | Input byte belongs to the sense reply |
| in_byte | output | 8 | Input byte |
| dma_en | output | 1 | DMA channel enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 error |
| csb | output | 8 | Last completion byte |
| irq_unexp | output | 1 | Sticky stray-interrupt flag |

## Verification
The interrupt acknowledge and a sequencer data-port write can both want the single write port in the same cycle. The bench raises interrupt status and `irq` in the exact cycle where the controller model is ready for the third command byte. It checks that this cycle carries the control-register zero write. After the transaction it checks that all six command bytes still arrived in order, and that exactly one acknowledge was counted.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_SEL, S_MODE, S_WSEL, S_WRDY, S_DMA, S_WDESEL
    } state_e;

    // status bit positions
    localparam int ST_RDY = 0;
    localparam int ST_IN  = 1;
    localparam int ST_CMD = 2;
    localparam int ST_SEL = 3;
    localparam int ST_INT = 4;

    localparam logic [1:0] A_SEL  = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // phase code = {command, input}
    typedef enum logic [1:0] {
        PH_OUT  = 2'b00,
        PH_IN   = 2'b01,
        PH_CMD  = 2'b10,
        PH_STAT = 2'b11
    } phase_e;

    localparam logic [1:0] RES_OK  = 2'd0;
    localparam logic [1:0] RES_TMO = 2'd1;
    localparam logic [1:0] RES_ERR = 2'd2;

endpackage

// File: rtl/phase_dec.sv
module phase_dec
    import dseq_pkg::*;
(
    input  logic [4:0] status,
    output phase_e     phase,
    output logic       rdy,
    output logic       sel,
    output logic       intr
);
    always_comb begin
        phase = phase_e'({status[ST_CMD], status[ST_IN]});
        rdy   = status[ST_RDY];
        sel   = status[ST_SEL];
        intr  = status[ST_INT];
    end
endmodule

// File: rtl/cmd_pick.sv
module cmd_pick #(
    parameter int CMD_LEN = 6,
    parameter int IDX_W   = 3
) (
    input  logic [8*CMD_LEN-1:0] bytes_i,
    input  logic [IDX_W-1:0]     idx,
    output logic [7:0]           byte_o
);
    logic [7:0] lane [CMD_LEN];

    for (genvar g = 0; g < CMD_LEN; g++) begin : g_lane
        assign lane[g] = bytes_i[8*g +: 8];
    end

    // indices past the block yield zero
    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < CMD_LEN; k++) begin
            if (idx == IDX_W'(k)) byte_o = lane[k];
        end
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)              cnt_d = '0;
        else if (cnt_q == limit) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == limit);

    a_r9_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/disk_phase_seq.sv
module disk_phase_seq
    import dseq_pkg::*;
#(
    parameter int         CMD_LEN  = 6,
    parameter int         TW       = 16,
    parameter logic [7:0] SENSE_OP = 8'h03,
    parameter logic [7:0] MODE_PIO = 8'h00,
    parameter logic [7:0] MODE_DMA = 8'h03,
    parameter int         ERR_BIT  = 1,
    parameter int         UNIT_LSB = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dma_mode,
    input  logic [8*CMD_LEN-1:0] cmd_bytes,
    input  logic                 src_en,
    input  logic [7:0]           src_data,
    input  logic                 dst_en,
    input  logic [TW-1:0]        tmo_limit,
    input  logic [4:0]           ctl_status,
    input  logic [7:0]           rd_data,
    input  logic                 irq,
    output logic                 bus_wr,
    output logic [1:0]           bus_addr,
    output logic [7:0]           bus_wdata,
    output logic                 bus_rd,
    output logic                 src_take,
    output logic                 in_we,
    output logic                 in_sense,
    output logic [7:0]           in_byte,
    output logic                 dma_en,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           result,
    output logic [7:0]           csb,
    output logic                 irq_unexp
);
    localparam int CW    = 8 * CMD_LEN;
    localparam int IDX_W = $clog2(CMD_LEN + 1);

    typedef struct packed {
        state_e         st;
        logic [CW-1:0]  cmd;
        logic [IDX_W-1:0] idx;
        logic           dma;
        logic           src;
        logic           dst;
        logic           sense;
        logic [TW-1:0]  tmo;
        logic [7:0]     csb;
        logic           done;
        logic [1:0]     res;
        logic           unexp;
    } ctx_t;

    ctx_t q, n;

    phase_e     phase;
    logic       rdy, sel, intr, ack;
    logic [7:0] cur_byte;
    logic       tm_clear, tm_exp;
    logic       s_wr, s_rd, s_take, s_inwe;
    logic [1:0] s_addr;
    logic [7:0] s_wdata;

    phase_dec u_dec (
        .status (ctl_status),
        .phase  (phase),
        .rdy    (rdy),
        .sel    (sel),
        .intr   (intr)
    );

    cmd_pick #(.CMD_LEN(CMD_LEN), .IDX_W(IDX_W)) u_pick (
        .bytes_i (q.cmd),
        .idx     (q.idx),
        .byte_o  (cur_byte)
    );

    wait_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tm_clear),
        .limit   (q.tmo),
        .expired (tm_exp)
    );

    assign ack = irq && intr;

    function automatic ctx_t fin(ctx_t c, logic [1:0] code);
        c.st   = S_IDLE;
        c.done = 1'b1;
        c.res  = c.sense ? RES_ERR : code;
        return c;
    endfunction

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        s_wr     = 1'b0;
        s_rd     = 1'b0;
        s_take   = 1'b0;
        s_inwe   = 1'b0;
        s_addr   = A_SEL;
        s_wdata  = 8'h00;
        tm_clear = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.st    = S_SEL;
                    n.cmd   = cmd_bytes;
                    n.idx   = '0;
                    n.dma   = dma_mode;
                    n.src   = src_en;
                    n.dst   = dst_en;
                    n.sense = 1'b0;
                    n.tmo   = tmo_limit;
                end
            end
            S_SEL: begin
                s_wr   = 1'b1;
                s_addr = A_SEL;
                n.st   = S_MODE;
            end
            S_MODE: begin
                s_wr    = 1'b1;
                s_addr  = A_CTRL;
                s_wdata = q.dma ? MODE_DMA : MODE_PIO;
                n.st    = S_WSEL;
            end
            S_WSEL: begin
                if (sel) n.st = S_WRDY;
                else begin
                    tm_clear = 1'b0;
                    if (tm_exp) n = fin(n, RES_TMO);
                end
            end
            S_WRDY: begin
                if (rdy) begin
                    unique case (phase)
                        PH_CMD: begin
                            s_wr    = 1'b1;
                            s_addr  = A_DATA;
                            s_wdata = cur_byte;
                            if (q.idx != IDX_W'(CMD_LEN)) n.idx = q.idx + 1'b1;
                        end
                        PH_OUT: begin
                            if (q.dma) n.st = S_DMA;
                            else begin
                                s_wr    = 1'b1;
                                s_addr  = A_DATA;
                                s_take  = q.src && !q.sense;
                                s_wdata = s_take ? src_data : 8'h00;
                            end
                        end
                        PH_IN: begin
                            if (q.dma) n.st = S_DMA;
                            else begin
                                s_rd   = 1'b1;
                                s_inwe = q.sense || q.dst;
                            end
                        end
                        PH_STAT: begin
                            s_rd = 1'b1;
                            if (!q.sense) n.csb = rd_data;
                            n.st = S_WDESEL;
                        end
                        default: ;
                    endcase
                end else begin
                    tm_clear = 1'b0;
                    if (tm_exp) n = fin(n, RES_TMO);
                end
            end
            S_DMA: begin
                if (ack) n.st = S_WRDY;
                else begin
                    tm_clear = 1'b0;
                    if (tm_exp) n = fin(n, RES_TMO);
                end
            end
            S_WDESEL: begin
                if (!sel) begin
                    if (!q.sense && q.csb[ERR_BIT]) begin
                        n.cmd       = '0;
                        n.cmd[7:0]  = SENSE_OP;
                        n.cmd[15:8] = {q.csb[7:UNIT_LSB], {UNIT_LSB{1'b0}}};
                        n.idx       = '0;
                        n.dma       = 1'b0;
                        n.sense     = 1'b1;
                        n.st        = S_SEL;
                    end else begin
                        n = fin(n, RES_OK);
                    end
                end else begin
                    tm_clear = 1'b0;
                    if (tm_exp) n = fin(n, RES_TMO);
                end
            end
            default: n.st = S_IDLE;
        endcase

        // acknowledge owns the port: hold any access wanted this cycle
        if (ack && (s_wr || s_rd)) begin
            n      = q;
            n.done = 1'b0;
            s_wr   = 1'b0;
            s_rd   = 1'b0;
            s_take = 1'b0;
            s_inwe = 1'b0;
        end

        if (q.st == S_IDLE && start) n.unexp = 1'b0;
        if (irq && !intr)            n.unexp = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ctx_t'('0);
        else        q <= n;
    end

    assign bus_wr    = ack || s_wr;
    assign bus_addr  = ack ? A_CTRL : s_addr;
    assign bus_wdata = ack ? 8'h00 : s_wdata;
    assign bus_rd    = s_rd;
    assign src_take  = s_take;
    assign in_we     = s_inwe;
    assign in_sense  = q.sense;
    assign in_byte   = rd_data;
    assign dma_en    = (q.st == S_DMA);
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign result    = q.res;
    assign csb       = q.csb;
    assign irq_unexp = q.unexp;

    a_r10_ack_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ctl_status[ST_INT]) |-> (bus_wr && bus_addr == A_CTRL && bus_wdata == 8'h00));

    a_r6_dma_no_pio_read: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> !bus_rd);

    a_r5_capture_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        in_we |-> bus_rd);

    a_r4_take_is_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |-> (bus_wr && bus_addr == A_DATA));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_unexp && !start) |=> irq_unexp);

    a_r8_result_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));

    a_r2_select_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WSEL && !sel && tm_exp && !q.sense) |=> (done && result == RES_TMO));
endmodule

// File: tb/disk_phase_seq_tb.sv
`timescale 1ns/1ps
module disk_phase_seq_tb;
    localparam int CMD_LEN = 6;
    localparam int TW      = 16;

    typedef struct packed {
        logic       dma;
        logic       s_en;
        logic       d_en;
        logic [3:0] nout;
        logic [3:0] nin;
        logic [7:0] csbv;
        logic [1:0] expr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 4'd3, 4'd0, 8'h00, 2'd0},
        '{1'b0, 1'b0, 1'b1, 4'd2, 4'd0, 8'h00, 2'd0},
        '{1'b0, 1'b1, 1'b1, 4'd0, 4'd4, 8'h00, 2'd0},
        '{1'b0, 1'b1, 1'b0, 4'd0, 4'd3, 8'h00, 2'd0},
        '{1'b1, 1'b1, 1'b1, 4'd5, 4'd0, 8'h00, 2'd0},
        '{1'b0, 1'b1, 1'b1, 4'd1, 4'd0, 8'hA2, 2'd2},
        '{1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 8'h01, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 start = 1'b0, dma_mode = 1'b0, src_en = 1'b0, dst_en = 1'b0;
    logic [8*CMD_LEN-1:0] cmd_bytes = '0;
    logic [7:0]           src_data;
    logic [TW-1:0]        tmo_limit = 16'd6;
    logic [4:0]           ctl_status;
    logic [7:0]           rd_data;
    logic                 irq;
    logic                 bus_wr, bus_rd, src_take, in_we, in_sense, dma_en, busy, done, irq_unexp;
    logic [1:0]           bus_addr, result;
    logic [7:0]           bus_wdata, in_byte, csb;

    disk_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode),
        .cmd_bytes(cmd_bytes), .src_en(src_en), .src_data(src_data), .dst_en(dst_en),
        .tmo_limit(tmo_limit), .ctl_status(ctl_status), .rd_data(rd_data), .irq(irq),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .src_take(src_take), .in_we(in_we), .in_sense(in_sense), .in_byte(in_byte),
        .dma_en(dma_en), .busy(busy), .done(done), .result(result), .csb(csb),
        .irq_unexp(irq_unexp)
    );

    // bench-side stimulus controls
    logic inj = 1'b0, uxp = 1'b0, mute = 1'b0, stall_rdy = 1'b0, new_tr = 1'b0;
    int   cfg_nout = 0, cfg_nin = 0;
    logic [7:0] cfg_csb = 8'h00;

    // controller model state
    logic m_sel, m_rdy, m_int, irq_p;
    int   m_ph, m_cnt, m_pass, m_nout, m_nin, m_drop, m_dma, sel_wr, ack_cnt, wr_n;
    logic [7:0] m_csb;
    logic [1:0] wa [2];
    logic [7:0] wd [2];
    logic [7:0] cmd_log [2][8];
    logic [7:0] out_log [16];

    assign ctl_status = {m_int | inj, m_sel, (m_ph == 0 || m_ph >= 3), (m_ph == 2 || m_ph >= 3), m_rdy};
    assign irq        = irq_p | inj | uxp;
    assign rd_data    = (m_ph == 2) ? (m_pass != 0 ? 8'(8'hC0 + m_cnt) : 8'(8'h50 + m_cnt)) : m_csb;

    always @(posedge clk) begin
        if (!rst_n || new_tr) begin
            m_sel <= 1'b0; m_rdy <= 1'b0; m_int <= 1'b0; irq_p <= 1'b0;
            m_ph <= 4; m_cnt <= 0; m_pass <= 0; m_nout <= 0; m_nin <= 0;
            m_drop <= 0; m_dma <= 0; sel_wr <= 0; ack_cnt <= 0; wr_n <= 0;
            m_csb <= 8'h00;
        end else begin
            irq_p <= 1'b0;
            if (bus_wr) begin
                if (wr_n < 2) begin
                    wa[wr_n] <= bus_addr;
                    wd[wr_n] <= bus_wdata;
                end
                wr_n <= wr_n + 1;
            end
            if (bus_wr && bus_addr == 2'd0) begin
                sel_wr <= sel_wr + 1;
                if (!mute) begin
                    m_sel <= 1'b1; m_rdy <= 1'b0; m_ph <= 0; m_cnt <= 0; m_dma <= 0; m_drop <= 0;
                    m_pass <= (sel_wr > 0) ? 1 : 0;
                    if (sel_wr > 0) begin
                        m_nout <= 0; m_nin <= 4; m_csb <= 8'h00;
                    end else begin
                        m_nout <= cfg_nout; m_nin <= cfg_nin; m_csb <= cfg_csb;
                    end
                end
            end else if (bus_wr && bus_addr == 2'd1) begin
                if (m_int || inj) begin
                    ack_cnt <= ack_cnt + 1;
                    m_int   <= 1'b0;
                end
            end else if (bus_wr && bus_addr == 2'd2) begin
                m_rdy <= 1'b0;
                if (m_ph == 0) begin
                    cmd_log[m_pass][m_cnt] <= bus_wdata;
                    if (m_cnt == CMD_LEN - 1) begin
                        m_cnt <= 0;
                        m_ph  <= (m_nout > 0) ? 1 : (m_nin > 0) ? 2 : 3;
                    end else m_cnt <= m_cnt + 1;
                end else if (m_ph == 1) begin
                    out_log[m_cnt] <= bus_wdata;
                    if (m_cnt == m_nout - 1) begin m_cnt <= 0; m_ph <= 3; end
                    else m_cnt <= m_cnt + 1;
                end
            end else if (bus_rd) begin
                m_rdy <= 1'b0;
                if (m_ph == 2) begin
                    if (m_cnt == m_nin - 1) begin m_cnt <= 0; m_ph <= 3; end
                    else m_cnt <= m_cnt + 1;
                end else if (m_ph == 3) begin
                    m_ph <= 4; m_drop <= 2;
                end
            end else if (m_sel && !m_rdy && m_ph < 4 && !stall_rdy && !m_int && m_dma == 0) begin
                m_rdy <= 1'b1;
            end
            if (dma_en && (m_ph == 1 || m_ph == 2) && m_dma == 0) m_dma <= 3;
            else if (m_dma > 1) m_dma <= m_dma - 1;
            else if (m_dma == 1) begin
                m_dma <= 0; m_int <= 1'b1; irq_p <= 1'b1; m_ph <= 3; m_rdy <= 1'b0;
            end
            if (m_drop == 1) m_sel <= 1'b0;
            if (m_drop > 0)  m_drop <= m_drop - 1;
        end
    end

    // capture of block outputs
    int n_in, n_sns, src_i, n_done;
    logic dma_seen;
    logic [7:0] in_log [16];
    logic [7:0] sns_log [8];
    assign src_data = 8'(8'hA0 + src_i);

    always @(posedge clk) begin
        if (!rst_n || new_tr) begin
            n_in <= 0; n_sns <= 0; src_i <= 0; dma_seen <= 1'b0; n_done <= 0;
        end else begin
            if (in_we) begin
                if (in_sense) begin sns_log[n_sns] <= in_byte; n_sns <= n_sns + 1; end
                else begin in_log[n_in] <= in_byte; n_in <= n_in + 1; end
            end
            if (src_take) src_i <= src_i + 1;
            if (dma_en)   dma_seen <= 1'b1;
            if (done)     n_done <= n_done + 1;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;
    logic [1:0] res_got;
    logic [7:0] csb_got;
    int tr_cycles;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic run_tr(input logic dma, input logic s_en, input logic d_en,
                          input int nout, input int nin, input logic [7:0] csbv,
                          input logic [TW-1:0] tmo, input int tagv);
        int c;
        cfg_nout = nout; cfg_nin = nin; cfg_csb = csbv;
        dma_mode = dma; src_en = s_en; dst_en = d_en; tmo_limit = tmo;
        for (int k = 0; k < CMD_LEN; k++) cmd_bytes[8*k +: 8] = 8'(16 * tagv + k + 1);
        @(negedge clk); new_tr = 1'b1;
        @(negedge clk); new_tr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        c = 1;
        while (!done && c < 2000) begin @(negedge clk); c++; end
        tr_cycles = c;
        check(done === 1'b1, "R12 transaction reached done", int'(done), 1);
        res_got = result;
        csb_got = csb;
        @(negedge clk);
    endtask

    task automatic check_cmd(input int pass, input int tagv, input string req);
        bit ok = 1;
        for (int k = 0; k < CMD_LEN; k++)
            if (cmd_log[pass][k] !== 8'(16 * tagv + k + 1)) ok = 0;
        check(ok, req, int'(cmd_log[pass][0]), 16 * tagv + 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(busy == 1'b0 && done == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0 && dma_en == 1'b0 && irq_unexp == 1'b0,
              "R12 reset state idle", int'({busy, done, bus_wr, dma_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table, tight limit (R9: count restarts at each wait)
        for (int v = 0; v < NV; v++) begin
            run_tr(VECS[v].dma, VECS[v].s_en, VECS[v].d_en, int'(VECS[v].nout),
                   int'(VECS[v].nin), VECS[v].csbv, 16'd6, v);
            check(wa[0] == 2'd0 && wd[0] == 8'h00 && wa[1] == 2'd1 &&
                  wd[1] == (VECS[v].dma ? 8'h03 : 8'h00), "R1 select then mode",
                  int'(wd[1]), VECS[v].dma ? 3 : 0);
            check_cmd(0, v, "R3 command bytes in order");
            check(res_got == VECS[v].expr, "R7 R9 result code", int'(res_got), int'(VECS[v].expr));
            check(csb_got == VECS[v].csbv, "R7 completion byte", int'(csb_got), int'(VECS[v].csbv));
            if (VECS[v].dma) begin
                check(dma_seen && ack_cnt == 1 && n_in == 0 && src_i == 0, "R6 DMA data phase",
                      ack_cnt, 1);
            end else begin
                for (int k = 0; k < int'(VECS[v].nout); k++)
                    check(out_log[k] == (VECS[v].s_en ? 8'(8'hA0 + k) : 8'h00), "R4 data out byte",
                          int'(out_log[k]), VECS[v].s_en ? 8'hA0 + k : 0);
                if (VECS[v].d_en) begin
                    check(n_in == int'(VECS[v].nin), "R5 data in count", n_in, int'(VECS[v].nin));
                    for (int k = 0; k < int'(VECS[v].nin); k++)
                        check(in_log[k] == 8'(8'h50 + k), "R5 data in byte", int'(in_log[k]), 8'h50 + k);
                end else begin
                    check(n_in == 0 && sel_wr == 1, "R5 discarded input not delivered", n_in, 0);
                end
            end
            if (VECS[v].csbv[1]) begin
                check(cmd_log[1][0] == 8'h03 && cmd_log[1][1] == {VECS[v].csbv[7:5], 5'b0} &&
                      cmd_log[1][2] == 8'h00 && cmd_log[1][5] == 8'h00,
                      "R8 sense command block", int'(cmd_log[1][1]), int'({VECS[v].csbv[7:5], 5'b0}));
                check(n_sns == 4 && sns_log[0] == 8'hC0 && sns_log[3] == 8'hC3, "R8 sense reply bytes",
                      n_sns, 4);
            end else begin
                check(sel_wr == 1, "R8 no sense on clean byte", sel_wr, 1);
            end
        end

        // R2: controller never selects
        mute = 1'b1;
        run_tr(1'b0, 1'b1, 1'b1, 0, 0, 8'h00, 16'd10, 1);
        check(res_got == 2'd1, "R2 select timeout result", int'(res_got), 1);
        check(tr_cycles >= 10, "R2 waited the full limit", tr_cycles, 10);
        mute = 1'b0;

        // R9: ready never returns after select
        stall_rdy = 1'b1;
        run_tr(1'b0, 1'b1, 1'b1, 0, 0, 8'h00, 16'd8, 2);
        check(res_got == 2'd1 && busy == 1'b0, "R9 ready timeout", int'(res_got), 1);
        stall_rdy = 1'b0;

        // R10: acknowledge in the cycle the third command byte is due
        fork
            run_tr(1'b0, 1'b1, 1'b1, 0, 0, 8'h00, 16'd6, 3);
            begin
                int c = 0;
                @(negedge clk); @(negedge clk);
                while (!(m_ph == 0 && m_cnt == 2 && m_rdy && m_sel) && c < 200) begin
                    @(negedge clk); c++;
                end
                inj = 1'b1;
                #1;
                check(bus_wr && bus_addr == 2'd1 && bus_wdata == 8'h00, "R10 ack takes the port",
                      int'(bus_addr), 1);
                @(negedge clk);
                inj = 1'b0;
            end
        join
        check_cmd(0, 3, "R10 held byte sent after ack");
        check(ack_cnt == 1 && res_got == 2'd0, "R10 one ack and clean end", ack_cnt, 1);

        // R11: stray interrupt while idle
        @(negedge clk); uxp = 1'b1;
        @(negedge clk); uxp = 1'b0;
        check(irq_unexp == 1'b1, "R11 stray irq flagged", int'(irq_unexp), 1);
        repeat (4) @(negedge clk);
        check(irq_unexp == 1'b1, "R11 flag sticky", int'(irq_unexp), 1);
        run_tr(1'b0, 1'b1, 1'b1, 0, 0, 8'h00, 16'd6, 4);
        check(irq_unexp == 1'b0, "R11 cleared by start", int'(irq_unexp), 0);

        // R12: start during a transaction is ignored
        mute = 1'b1;
        fork
            run_tr(1'b0, 1'b1, 1'b1, 0, 0, 8'h00, 16'd30, 5);
            begin
                repeat (8) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (40) @(negedge clk);
        check(sel_wr == 1 && n_done == 1 && res_got == 2'd1, "R12 second start ignored", sel_wr, 1);
        mute = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule